// File: doc/BRIEF.md
# Latched One-Hot Select Decoder

This block turns a 4-bit select code into a 16-line active-high one-hot vector. A small register stage in front of the decoder holds the code. While the load enable is high, the decoder sees the live select bus and the register follows it on every clock edge. When the enable is low, the decoder sees the value the register captured at the last rising edge on which the enable was high. Later changes on the select bus have no effect until the enable returns high.

A blanking input forces all sixteen lines low. It acts only on the output stage, so the held code survives blanking and reappears when blanking is released. A synchronous active-low reset clears the held code to zero.

Every pin is a plain control or data level. There is no handshake, because the block has no stream interface.

Top module: `latched_onehot_dec`

## Requirements
- R1: While `load_en_i` is high, `hot_o` reflects the present value of `sel_i` in the same cycle, with no clock delay.
- R2: While `load_en_i` is low, `hot_o` decodes the code that `sel_i` carried at the last rising clock edge on which `load_en_i` was high. Changes on `sel_i` in that time have no effect on `hot_o`.
- R3: `sel_i[3]` is the most significant bit. A code value k drives `hot_o[k]` high: code 0 drives bit 0, code 8 drives bit 8, and code 15 drives bit 15.
- R4: While `blank_i` is low, exactly one bit of `hot_o` is high.
- R5: While `blank_i` is high, `hot_o` is all zero, whatever `load_en_i` and `sel_i` do.
- R6: `blank_i` does not alter the held code. After blanking is released with `load_en_i` low, `hot_o` shows the same code as before blanking.
- R7: A rising edge with `rst_n` low clears the held code to 0. With `load_en_i` low and `blank_i` low afterwards, `hot_o` equals 16'h0001. Reset takes priority over loading.
- R8: When `load_en_i` returns high after a hold period, `hot_o` follows `sel_i` again at once, and the register reloads on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the code register |
| rst_n | input | 1 | Synchronous active-low reset of the held code |
| sel_i | input | 4 | Select code, bit 3 most significant |
| load_en_i | input | 1 | High: transparent and loading. Low: hold |
| blank_i | input | 1 | High forces all outputs low |
| hot_o | output | 16 | One-hot decoded output, active high |

## Verification
The clocked properties assume that `sel_i`, `load_en_i` and `blank_i` are stable around each rising edge, and that they are known once reset has been applied. The bench meets this by changing every input only on the falling edge. It samples `hot_o` a quarter period later, well before the next rising edge. It also drives known values from time zero, so the register is in a defined state before the first property is evaluated.

// File: rtl/ldec_pkg.sv
package ldec_pkg;
  localparam int unsigned CODE_W_DEF = 4;

  function automatic int unsigned lines_for(input int unsigned w);
    return 32'd1 << w;
  endfunction
endpackage

// File: rtl/ldec_code_hold.sv
module ldec_code_hold #(
  parameter int unsigned CODE_W = ldec_pkg::CODE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] sel_i,
  input  logic              load_en_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         held_q <= '0;
    else if (load_en_i) held_q <= sel_i;
  end

  // transparent path when loading, register otherwise
  assign code_o = load_en_i ? sel_i : held_q;

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en_i |=> $stable(held_q));

  // R8
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en_i |=> held_q == $past(sel_i));
endmodule

// File: rtl/ldec_line_drv.sv
module ldec_line_drv #(
  parameter int unsigned CODE_W = ldec_pkg::CODE_W_DEF,
  localparam int unsigned LINES = ldec_pkg::lines_for(CODE_W)
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              blank_i,
  output logic [LINES-1:0]  line_o
);
  for (genvar k = 0; k < LINES; k++) begin : g_line
    assign line_o[k] = !blank_i && (code_i == CODE_W'(k));
  end
endmodule

// File: rtl/latched_onehot_dec.sv
module latched_onehot_dec #(
  parameter int unsigned CODE_W = ldec_pkg::CODE_W_DEF,
  localparam int unsigned LINES = ldec_pkg::lines_for(CODE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] sel_i,
  input  logic              load_en_i,
  input  logic              blank_i,
  output logic [LINES-1:0]  hot_o
);
  logic [CODE_W-1:0] code_w;

  ldec_code_hold #(.CODE_W(CODE_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (sel_i),
    .load_en_i (load_en_i),
    .code_o    (code_w)
  );

  ldec_line_drv #(.CODE_W(CODE_W)) u_drv (
    .code_i  (code_w),
    .blank_i (blank_i),
    .line_o  (hot_o)
  );

  // R4
  single_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_i |-> $countones(hot_o) == 1);

  // R5
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_i |-> $countones(hot_o) == 0);

  // R3
  index_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_i |-> hot_o[code_w]);

  // R1
  live_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en_i && !blank_i) |-> hot_o[sel_i]);
endmodule

// File: tb/latched_onehot_dec_tb.sv
module latched_onehot_dec_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  sel_i = 4'd7;
  logic        load_en_i = 1'b0;
  logic        blank_i = 1'b0;
  logic [15:0] hot_o;

  int applied = 0;
  int fails = 0;
  bit done = 1'b0;

  latched_onehot_dec u_dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i),
    .load_en_i(load_en_i), .blank_i(blank_i), .hot_o(hot_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {load_en, blank, sel[3:0], expected[15:0]}
  localparam int NV = 13;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'd5,  16'h0020},  // R1 live
    {1'b1, 1'b0, 4'd15, 16'h8000},  // R3 top code
    {1'b1, 1'b0, 4'd0,  16'h0001},  // R3 bottom code
    {1'b1, 1'b0, 4'd9,  16'h0200},  // R1
    {1'b0, 1'b0, 4'd3,  16'h0200},  // R2 hold
    {1'b0, 1'b0, 4'd12, 16'h0200},  // R2 hold
    {1'b0, 1'b1, 4'd6,  16'h0000},  // R5 blank while holding
    {1'b0, 1'b0, 4'd6,  16'h0200},  // R6 reappears
    {1'b1, 1'b1, 4'd2,  16'h0000},  // R5 blank while loading
    {1'b0, 1'b0, 4'd11, 16'h0004},  // R6 load under blank kept
    {1'b1, 1'b0, 4'd8,  16'h0100},  // R8 resume, R3 msb
    {1'b1, 1'b0, 4'd1,  16'h0002},  // R8
    {1'b0, 1'b0, 4'd14, 16'h0002}   // R2
  };

  task automatic check(input logic [15:0] exp, input string req);
    applied++;
    if (hot_o !== exp) begin
      fails++;
      $display("FAIL %s: hot_o=%h expected=%h", req, hot_o, exp);
    end
    if (!blank_i && $countones(hot_o) != 1) begin
      fails++;
      $display("FAIL R4: hot_o=%h expected one bit set", hot_o);
    end
  endtask

  task automatic drive(input logic le, input logic bl, input logic [3:0] s);
    @(negedge clk);
    load_en_i = le; blank_i = bl; sel_i = s;
    #(CLK_PERIOD/4);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    // R7 reset state
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #(CLK_PERIOD/4);
    check(16'h0001, "R7");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][21], VEC[i][20], VEC[i][19:16]);
      check(VEC[i][15:0], "R1/R2/R3/R5/R6/R8 table");
    end

    // R3 all codes live
    for (int k = 0; k < 16; k++) begin
      drive(1'b1, 1'b0, 4'(k));
      check(16'(32'd1 << k), "R3");
    end

    // R2 sweep select while holding code 15
    for (int k = 0; k < 16; k++) begin
      drive(1'b0, 1'b0, 4'(k));
      check(16'h8000, "R2");
    end

    // R5 blank over every code with enable high
    for (int k = 0; k < 16; k++) begin
      drive(1'b1, 1'b1, 4'(k));
      check(16'h0000, "R5");
    end

    // R7 reset with load enable high: reset wins
    drive(1'b1, 1'b0, 4'd10);
    check(16'h0400, "R1");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; load_en_i = 1'b0; sel_i = 4'd13;
    #(CLK_PERIOD/4);
    check(16'h0001, "R7");

    // R6 hold through long blank
    drive(1'b1, 1'b0, 4'd12);
    drive(1'b0, 1'b1, 4'd4);
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    check(16'h0000, "R5");
    drive(1'b0, 1'b0, 4'd4);
    check(16'h1000, "R6");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule